// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins and turns their activity into interrupt requests for a processor. Each pin is first brought into the clock domain by a small synchroniser. A per-pin detector then recognises the condition the pin is programmed for: a falling edge, a rising edge, both edges, a low level or a high level. Detected events are held in a pending flag that software reads and acknowledges over a simple word-wide register bus.

A pin raises its request only when its pending flag is set, it is not masked, and its 4-bit priority field is nonzero. Masking is controlled through two write-only registers, one that sets mask bits and one that clears them, so that software never needs a read-modify-write to mask a single pin. A control bit selects whether the per-pin request lines are driven; the shared line, which is the OR of every qualified request, is always driven. Per-pin bits and fields are laid out most-significant first: pin 0 owns the top bit or top field.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset every pin is masked, every priority and sense field is 0, every pending flag is 0, the control word reads 0 and both request outputs are low.
- R2: In the sense and priority words (register index 0 and 1), pin n owns the field at bit offset 32 - (n+1)*W (W = 4 for priority, the configured sense width for sense), so pin 0 holds bits 31:28; fields read back as written.
- R3: Sense codes 0 (falling), 1 (rising) and 4 (both) set the pending flag on the matching synchronised edge, and the flag stays set after the pin returns.
- R4: Sense codes 2 (low level) and 3 (high level) make the pending flag follow the synchronised pin: set while the level is active, clear once it is not.
- R5: Sense codes 5 to 15 never set the pending flag.
- R6: A pin change driven before clock edge k shows on the pending flag and on the request at edge k+2 (two synchroniser stages, then the detector), not earlier.
- R7: The pending word (register index 2) places pin n at bit SRC_W-1-n; a write clears every pin whose bit is written 0 and leaves pins whose bit is written 1 unchanged.
- R8: Writing 1 to a pin's bit in the mask-set word (index 3) masks it, writing 1 in the mask-clear word (index 4) unmasks it, bits written 0 change nothing, and both words read as 0; masking does not alter the pending flag.
- R9: A pin whose priority field is 0 raises no request, while its pending flag is kept.
- R10: Control word (index 5) bit 23 enables the per-pin request lines; while it is 0 every per-pin line stays low and the shared line still works.
- R11: The shared line is high exactly when at least one pin is pending, unmasked and of nonzero priority.
- R12: Read data for a request presented at one clock edge is on the read-data port after that edge and stays until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | NUM_PINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all qualified requests |

## Verification
A pin change is due on the request three rising edges after it is driven, so the bench drives pins on a falling edge and samples on the third falling edge after that, and also samples one edge early to prove the request has not yet appeared. Register writes act at the edge that accepts them and the request logic after the pending, mask and priority state is combinational, so every mask, priority, mode and acknowledge effect is sampled on the falling edge right after the write. Reads return on the falling edge after the request, which the bench's read task relies on for every register readback.

// File: rtl/extpin_pkg.sv
package extpin_pkg;
  localparam int MAX_PINS = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int PRIO_W   = 4;

  localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRIO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

  typedef enum logic [3:0] {
    SNS_FALL = 4'd0,
    SNS_RISE = 4'd1,
    SNS_LOW  = 4'd2,
    SNS_HIGH = 4'd3,
    SNS_BOTH = 4'd4
  } sense_e;

  // lowest bit of pin's field, MSB-first packing
  function automatic int field_lsb(int pin, int fw);
    return DATA_W - (pin + 1) * fw;
  endfunction

  // mask covering the fields of the first np pins
  function automatic logic [DATA_W-1:0] used_fields(int np, int fw);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int n = 0; n < MAX_PINS; n++)
      if (n < np)
        for (int b = 0; b < fw; b++) r[field_lsb(n, fw) + b] = 1'b1;
    return r;
  endfunction

  // word bit (sw-1-n) belongs to pin n
  function automatic logic [MAX_PINS-1:0] word_to_pins(logic [DATA_W-1:0] w, int sw);
    logic [MAX_PINS-1:0] r;
    for (int n = 0; n < MAX_PINS; n++) r[n] = w[sw-1-n];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pins_to_word(logic [MAX_PINS-1:0] p, int sw);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int n = 0; n < MAX_PINS; n++) r[sw-1-n] = p[n];
    return r;
  endfunction
endpackage

// File: rtl/extpin_sync.sv
module extpin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/extpin_cell.sv
module extpin_cell
  import extpin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [3:0] code,
  input  logic       ack_clr,
  output logic       pend,
  output logic       hit
);
  logic prev_q;
  logic rise, fall;
  logic edge_set, is_level, lvl_active;
  logic pend_d;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    edge_set   = 1'b0;
    is_level   = 1'b0;
    lvl_active = 1'b0;
    case (code)
      SNS_FALL: edge_set = fall;
      SNS_RISE: edge_set = rise;
      SNS_BOTH: edge_set = rise | fall;
      SNS_LOW:  begin is_level = 1'b1; lvl_active = ~lvl; end
      SNS_HIGH: begin is_level = 1'b1; lvl_active = lvl;  end
      default:  ;
    endcase
  end

  assign hit = edge_set | (is_level & lvl_active);

  // level modes track the pin; edge modes latch, a new edge beats an acknowledge
  always_comb begin
    if (is_level)      pend_d = lvl_active;
    else if (edge_set) pend_d = 1'b1;
    else if (ack_clr)  pend_d = 1'b0;
    else               pend_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend   <= pend_d;
    end
  end
endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl
  import extpin_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 32,
  parameter int MODE_BIT = 23,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                irq_any
);
  localparam logic [DATA_W-1:0] SENSE_USED = used_fields(NUM_PINS, SENSE_W);
  localparam logic [DATA_W-1:0] PRIO_USED  = used_fields(NUM_PINS, PRIO_W);

  logic [DATA_W-1:0]   sense_q, prio_q;
  logic [NUM_PINS-1:0] mask_q;
  logic                mode_q;
  logic [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] pend_vec, hit_vec, ack_vec, prio_nz, qual_vec;
  logic [MAX_PINS-1:0] wpins_full, pend_full;
  logic [NUM_PINS-1:0] wpins;
  logic                wr_en, rd_en;
  logic [DATA_W-1:0]   rd_mux;

  assign wr_en      = bus_valid & bus_write;
  assign rd_en      = bus_valid & ~bus_write;
  assign wpins_full = word_to_pins(bus_wdata, SRC_W);
  assign wpins      = wpins_full[NUM_PINS-1:0];

  extpin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_lvl)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int SLSB = field_lsb(n, SENSE_W);
    localparam int PLSB = field_lsb(n, PRIO_W);
    logic [3:0] code_n;
    assign code_n     = 4'(sense_q[SLSB +: SENSE_W]);
    assign prio_nz[n] = |prio_q[PLSB +: PRIO_W];
    assign ack_vec[n] = wr_en && (bus_addr == A_PEND) && !wpins[n];

    extpin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[n]), .code(code_n),
      .ack_clr(ack_vec[n]), .pend(pend_vec[n]), .hit(hit_vec[n])
    );
  end

  assign qual_vec = pend_vec & ~mask_q & prio_nz;
  assign irq_req  = mode_q ? qual_vec : '0;
  assign irq_any  = |qual_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      prio_q  <= '0;
      mask_q  <= '1;
      mode_q  <= 1'b0;
    end else if (wr_en) begin
      case (bus_addr)
        A_SENSE: sense_q <= bus_wdata & SENSE_USED;
        A_PRIO:  prio_q  <= bus_wdata & PRIO_USED;
        A_MSET:  mask_q  <= mask_q | wpins;
        A_MCLR:  mask_q  <= mask_q & ~wpins;
        A_CTRL:  mode_q  <= bus_wdata[MODE_BIT];
        default: ;
      endcase
    end
  end

  assign pend_full = MAX_PINS'(pend_vec);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_SENSE: rd_mux = sense_q;
      A_PRIO:  rd_mux = prio_q;
      A_PEND:  rd_mux = pins_to_word(pend_full, SRC_W);
      A_CTRL:  rd_mux[MODE_BIT] = mode_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/extpin_irq_chk.sv
module extpin_irq_chk
  import extpin_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SRC_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [2:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] irq_req,
  input logic                irq_any,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] prio_nz,
  input logic                mode
);
  logic [MAX_PINS-1:0] wmap_full;
  logic [NUM_PINS-1:0] wmap;
  assign wmap_full = word_to_pins(bus_wdata, SRC_W);
  assign wmap      = wmap_full[NUM_PINS-1:0];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '1 && pend == '0 && !irq_any));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_MSET) |=> ((mask & $past(wmap)) == $past(wmap)));

  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_MCLR) |=> ((mask & $past(wmap)) == '0));

  assert_prio_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~prio_nz) == '0);

  assert_mode_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (irq_req == '0));

  assert_shared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> irq_any);

  assert_shared_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((pend & ~mask) != '0));
endmodule

bind extpin_irq_ctrl extpin_irq_chk #(.NUM_PINS(NUM_PINS), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_req(irq_req), .irq_any(irq_any),
  .pend(pend_vec), .mask(mask_q), .prio_nz(prio_nz), .mode(mode_q)
);

// File: tb/tb_extpin_irq_ctrl.sv
module tb_extpin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req;
  logic        irq_any;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;  // 250 MHz

  extpin_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_any(irq_any)
  );

  // {sense code, start level, end level, expected pending} for pin 0
  localparam logic [6:0] VEC [12] = '{
    {4'd0, 1'b1, 1'b0, 1'b1}, {4'd0, 1'b0, 1'b1, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b1}, {4'd1, 1'b1, 1'b0, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1}, {4'd2, 1'b0, 1'b1, 1'b0},
    {4'd3, 1'b0, 1'b1, 1'b1}, {4'd3, 1'b1, 1'b0, 1'b0},
    {4'd4, 1'b1, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b1, 1'b1},
    {4'd5, 1'b0, 1'b1, 1'b0}, {4'd15, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;  // R12: valid one edge after the request
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 irq_req", 32'(irq_req), 32'h0);
    chk("R1 irq_any", 32'(irq_any), 32'h0);
    rdr(3'd0, rd); chk("R1 sense", rd, 32'h0);
    rdr(3'd1, rd); chk("R1 prio", rd, 32'h0);
    rdr(3'd2, rd); chk("R1 pending", rd, 32'h0);
    rdr(3'd5, rd); chk("R1 control", rd, 32'h0);

    // pin 0 pending and enabled, but masked from reset
    wr(3'd1, 32'hF000_0000);
    wr(3'd5, 32'h0080_0000);
    wr(3'd0, 32'h1000_0000);
    pin_in[0] = 1'b1;
    wait_n(4);
    chk("R1 masked after reset", 32'(irq_req), 32'h0);
    rdr(3'd2, rd); chk("R1 pending latched", rd, 32'h8000_0000);
    wr(3'd4, 32'h8000_0000);
    chk("R8 unmask", 32'(irq_req), 32'h1);
    pin_in[0] = 1'b0;
    wait_n(4);

    // sense modes R3 R4 R5
    for (int v = 0; v < 12; v++) begin
      logic [3:0] code;
      code = VEC[v][6:3];
      wr(3'd0, {code, 28'h0});
      pin_in[0] = VEC[v][2];
      wait_n(5);
      wr(3'd2, 32'h0);
      pin_in[0] = VEC[v][1];
      wait_n(3);
      chk($sformatf("R3/R4/R5 code %0d req", code), 32'(irq_req[0]), 32'(VEC[v][0]));
      rdr(3'd2, rd);
      chk($sformatf("R3/R4/R5 code %0d pend", code), 32'(rd[31]), 32'(VEC[v][0]));
    end

    // R6 latency, R7 acknowledge
    wr(3'd0, 32'h1100_0000);
    wr(3'd1, 32'hFF00_0000);
    wr(3'd4, 32'hC000_0000);
    pin_in = '0;
    wait_n(5);
    wr(3'd2, 32'h0);
    pin_in[1] = 1'b1;
    wait_n(2);
    chk("R6 not early", 32'(irq_req[1]), 32'h0);
    wait_n(1);
    chk("R6 on time", 32'(irq_req[1]), 32'h1);
    pin_in[0] = 1'b1;
    wait_n(3);
    chk("R6 both pins", 32'(irq_req), 32'h3);
    wr(3'd2, 32'h8000_0000);
    chk("R7 partial ack req", 32'(irq_req), 32'h1);
    rdr(3'd2, rd); chk("R7 partial ack pend", rd, 32'h8000_0000);

    // R8 masks, R11 shared line
    wr(3'd3, 32'h8000_0000);
    chk("R8 mask set", 32'(irq_req), 32'h0);
    chk("R11 shared low", 32'(irq_any), 32'h0);
    rdr(3'd2, rd); chk("R8 pending kept", rd, 32'h8000_0000);
    wr(3'd4, 32'h0);
    chk("R8 zero write no effect", 32'(irq_req), 32'h0);
    rdr(3'd3, rd); chk("R8 mset reads 0", rd, 32'h0);
    rdr(3'd4, rd); chk("R8 mclr reads 0", rd, 32'h0);
    wr(3'd4, 32'h8000_0000);
    chk("R8 mask clear", 32'(irq_req), 32'h1);
    chk("R11 shared high", 32'(irq_any), 32'h1);

    // R9 priority zero
    wr(3'd1, 32'h0F00_0000);
    chk("R9 prio zero req", 32'(irq_req), 32'h0);
    chk("R9 prio zero any", 32'(irq_any), 32'h0);
    rdr(3'd2, rd); chk("R9 pending kept", rd, 32'h8000_0000);
    wr(3'd1, 32'hFF00_0000);
    chk("R9 prio restored", 32'(irq_req), 32'h1);

    // R10 mode bit
    wr(3'd5, 32'h0);
    chk("R10 per-pin off", 32'(irq_req), 32'h0);
    chk("R10 shared on", 32'(irq_any), 32'h1);
    rdr(3'd5, rd); chk("R10 ctrl 0", rd, 32'h0);
    wr(3'd5, 32'h0080_0000);
    chk("R10 per-pin on", 32'(irq_req), 32'h1);
    rdr(3'd5, rd); chk("R10 ctrl bit 23", rd, 32'h0080_0000);

    // R2 field layout
    rdr(3'd0, rd); chk("R2 sense readback", rd, 32'h1100_0000);
    wr(3'd1, 32'h0000_000A);
    rdr(3'd1, rd); chk("R2 prio readback", rd, 32'h0000_000A);
    chk("R2 pin7 field not pin0", 32'(irq_req), 32'h0);

    // R7 write of zeros clears all
    wr(3'd2, 32'h0);
    rdr(3'd2, rd); chk("R7 clear all", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule